// File: doc/BRIEF.md
# Tagged Translation Cache for an I/O MMU

This block is a small, fully associative cache of address translations for an I/O memory management unit. Each entry carries a 16-bit address-space identifier (ASID) and a page-aligned input address as its tag. Its payload is an output page address and one write-permission bit. A lookup presents an ASID, an input address, a granule size and an access type. One cycle later the block answers with hit or miss, a permission fault flag, and the translated address with the in-page offset restored.

After a miss, the surrounding walker inserts the translation through the fill port. Software-driven maintenance uses the invalidation port. It can drop every entry, every entry of one ASID, or one exact ASID and address pair. When a new entry arrives and the cache is already full, the whole cache is emptied and then the new entry is written. No victim is chosen. Two saturating counters record how many lookups hit and how many missed.

Top module: `iotlb_cache`

## Requirements
- R1: A lookup hits only a valid entry whose ASID equals `lk_asid` and whose stored tag equals `lk_addr` with its low `lk_gran` bits cleared. A fill stores `fill_addr` with its low `fill_gran` bits cleared as the tag.
- R2: A lookup with a different ASID misses, even when the aligned address matches.
- R3: On a hit, `rsp_addr` is the stored page address plus the low `lk_gran` bits of `lk_addr`. On a miss, `rsp_addr` is 0.
- R4: A write lookup (`lk_write`=1) that hits an entry whose write permission is 0 gives `rsp_hit`=1 and `rsp_fault`=1. Read hits, and write hits on writable entries, give `rsp_fault`=0. A miss never faults.
- R5: The response appears on `rsp_*` exactly one cycle after `lk_valid`, with `rsp_valid`=1. The lookup sees the contents as they were before any fill or invalidation in the same cycle. `rsp_valid` is 0 in cycles that follow no lookup.
- R6: A fill of a new key while all 16 entries are valid first invalidates every entry, then inserts the new one. Afterwards only the new entry hits.
- R7: The invalidation scopes are encoded in `inv_scope`:
  - 2'b00 clears all entries.
  - 2'b01 clears every entry whose ASID equals `inv_asid`.
  - 2'b10 clears only the entry whose ASID equals `inv_asid` and whose tag equals `inv_addr`.
  - 2'b11 has no effect.
- R8: When a fill and an invalidation fall in the same cycle, the invalidation is applied first and the fill second, so the filled entry survives.
- R9: A fill whose ASID and aligned address match an existing valid entry overwrites that entry in place. It does not flush the cache and does not create a duplicate.
- R10: Each lookup increments exactly one of `hit_count` and `miss_count`, in the same cycle that its response appears. Both counters saturate at their all-ones value.
- R11: Reset empties the cache, clears both counters and drives `rsp_valid`, `rsp_hit` and `rsp_fault` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| lk_addr | input | ADDR_W | Lookup input address |
| lk_gran | input | log2(ADDR_W) | Lookup granule size, as a number of offset bits |
| lk_write | input | 1 | Lookup is a write access |
| fill_valid | input | 1 | Insert request |
| fill_asid | input | ASID_W | ASID of the inserted entry |
| fill_addr | input | ADDR_W | Input address of the inserted entry |
| fill_gran | input | log2(ADDR_W) | Granule size of the inserted entry |
| fill_page | input | ADDR_W | Output page address of the inserted entry |
| fill_wr_ok | input | 1 | Inserted entry permits writes |
| inv_valid | input | 1 | Invalidation request |
| inv_scope | input | 2 | Invalidation scope (see R7) |
| inv_asid | input | ASID_W | ASID for scoped invalidation |
| inv_addr | input | ADDR_W | Aligned tag for pair invalidation |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_fault | output | 1 | Write hit without permission |
| rsp_addr | output | ADDR_W | Translated address |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |

## Verification
Fills and invalidations can land in the same clock edge, and the ordering rule between them is the risky part. The bench issues both in one cycle in two cases. In the first, an invalidate-all arrives alongside a fill, and the filled entry must then hit. In the second, an ASID-scoped invalidation arrives alongside a fill of that same ASID: the older entry of that ASID must miss and the new one must hit. A lookup is also placed in the same cycle as a pair invalidation of the entry it targets. It must still hit, which confirms that lookups see the contents from before that edge.

// File: rtl/iotlb_cache.sv
module iotlb_cache #(
  parameter int ENTRIES = 16,
  parameter int ASID_W  = 16,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 32,
  localparam int GW = $clog2(ADDR_W),
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [GW-1:0]     lk_gran,
  input  logic              lk_write,
  input  logic              fill_valid,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [GW-1:0]     fill_gran,
  input  logic [ADDR_W-1:0] fill_page,
  input  logic              fill_wr_ok,
  input  logic              inv_valid,
  input  logic [1:0]        inv_scope,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);

  logic [ENTRIES-1:0] vld, hit_vec, kill, dup_vec, vld_post, vld_next;
  logic [ASID_W-1:0]  e_asid [ENTRIES];
  logic [ADDR_W-1:0]  e_va   [ENTRIES];
  logic [ADDR_W-1:0]  e_pa   [ENTRIES];
  logic [ENTRIES-1:0] e_wr;

  logic [ADDR_W-1:0] lk_mask, lk_tag, fill_mask, fill_tag, hit_pa;
  logic              hit_wr, any_hit, flush;
  logic [IW-1:0]     slot;

  assign lk_mask   = (ADDR_W'(1) << lk_gran) - ADDR_W'(1);
  assign lk_tag    = lk_addr & ~lk_mask;
  assign fill_mask = (ADDR_W'(1) << fill_gran) - ADDR_W'(1);
  assign fill_tag  = fill_addr & ~fill_mask;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign hit_vec[i] = vld[i] && e_asid[i] == lk_asid && e_va[i] == lk_tag;
    assign kill[i]    = inv_valid && (inv_scope == 2'b00 ||
                        (e_asid[i] == inv_asid &&
                         (inv_scope == 2'b01 ||
                          (inv_scope == 2'b10 && e_va[i] == inv_addr))));
    assign dup_vec[i] = vld_post[i] && e_asid[i] == fill_asid && e_va[i] == fill_tag;
  end

  assign vld_post = vld & ~kill;
  assign any_hit  = |hit_vec;
  assign flush    = fill_valid && (&vld_post) && !(|dup_vec);

  always_comb begin
    hit_pa = '0;
    hit_wr = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) begin
        hit_pa = hit_pa | e_pa[i];
        hit_wr = hit_wr | e_wr[i];
      end
  end

  always_comb begin
    slot = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld_post[i]) slot = IW'(i);
    if (|dup_vec) begin
      for (int i = 0; i < ENTRIES; i++)
        if (dup_vec[i]) slot = IW'(i);
    end else if (&vld_post) begin
      slot = '0;
    end
  end

  always_comb begin
    vld_next = flush ? '0 : vld_post;
    if (fill_valid) vld_next[slot] = 1'b1;
  end

  always_ff @(posedge clk)
    if (fill_valid) begin
      e_asid[slot] <= fill_asid;
      e_va[slot]   <= fill_tag;
      e_pa[slot]   <= fill_page;
      e_wr[slot]   <= fill_wr_ok;
    end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld        <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_addr   <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      vld       <= vld_next;
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && any_hit;
      rsp_fault <= lk_valid && any_hit && lk_write && !hit_wr;
      rsp_addr  <= (lk_valid && any_hit) ? hit_pa + (lk_addr & lk_mask) : '0;
      if (lk_valid && any_hit && hit_count != '1)   hit_count  <= hit_count + 1'b1;
      if (lk_valid && !any_hit && miss_count != '1) miss_count <= miss_count + 1'b1;
    end
  end

endmodule

// File: rtl/iotlb_cache_chk.sv
module iotlb_cache_chk #(
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_write,
  input logic               fill_valid,
  input logic               inv_valid,
  input logic [1:0]         inv_scope,
  input logic [ENTRIES-1:0] vld,
  input logic [ENTRIES-1:0] hit_vec,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_fault,
  input logic [CNT_W-1:0]   hit_count,
  input logic [CNT_W-1:0]   miss_count
);

  a_r5_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  a_r5_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid && !rsp_hit);

  a_r4_fault_needs_write_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_hit && $past(lk_write));

  a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r7_inv_all_empties: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && inv_scope == 2'b00 && !fill_valid |=> vld == '0);

  a_r8_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> vld != '0);

  a_r10_hit_step: assert property (@(posedge clk) disable iff (!rst_n)
    hit_count == $past(hit_count) || hit_count == CNT_W'($past(hit_count) + 1'b1));

  a_r10_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
    miss_count == $past(miss_count) || miss_count == CNT_W'($past(miss_count) + 1'b1));

  a_r11_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> vld == '0);

endmodule

bind iotlb_cache iotlb_cache_chk #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
  .fill_valid(fill_valid), .inv_valid(inv_valid), .inv_scope(inv_scope),
  .vld(vld), .hit_vec(hit_vec), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_fault(rsp_fault), .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/sim_iotlb_cache.sv
module sim_iotlb_cache;
  localparam int CW = 4;

  logic        clk = 0, rst_n = 0;
  logic        lk_valid = 0, lk_write = 0;
  logic [15:0] lk_asid = 0;
  logic [31:0] lk_addr = 0;
  logic [4:0]  lk_gran = 0;
  logic        fill_valid = 0, fill_wr_ok = 0;
  logic [15:0] fill_asid = 0;
  logic [31:0] fill_addr = 0, fill_page = 0;
  logic [4:0]  fill_gran = 0;
  logic        inv_valid = 0;
  logic [1:0]  inv_scope = 0;
  logic [15:0] inv_asid = 0;
  logic [31:0] inv_addr = 0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [31:0] rsp_addr;
  logic [CW-1:0] hit_count, miss_count;

  int checks = 0, errors = 0, nh = 0, nm = 0;
  bit done = 0;

  iotlb_cache #(.CNT_W(CW)) u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(string r, logic [63:0] a, logic [63:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, a, e);
    end
  endtask

  task automatic look(string r, int asid, logic [31:0] addr, int gran, bit wr,
                      bit eh, bit ef, logic [31:0] ea);
    lk_valid = 1; lk_asid = 16'(asid); lk_addr = addr; lk_gran = 5'(gran); lk_write = wr;
    @(negedge clk);
    lk_valid = 0;
    if (eh) nh++; else nm++;
    chk({r, " R5 valid"}, rsp_valid, 1);
    chk({r, " hit"}, rsp_hit, eh);
    chk({r, " R4 fault"}, rsp_fault, ef);
    chk({r, " R3 addr"}, rsp_addr, ea);
    chk("R10 hits", hit_count, (nh > 15) ? 15 : nh);
    chk("R10 misses", miss_count, (nm > 15) ? 15 : nm);
  endtask

  task automatic fill(int asid, logic [31:0] addr, int gran, logic [31:0] page, bit wr);
    fill_valid = 1; fill_asid = 16'(asid); fill_addr = addr; fill_gran = 5'(gran);
    fill_page = page; fill_wr_ok = wr;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic inv(logic [1:0] sc, int asid, logic [31:0] addr);
    inv_valid = 1; inv_scope = sc; inv_asid = 16'(asid); inv_addr = addr;
    @(negedge clk);
    inv_valid = 0;
  endtask

  task automatic t_reset;
    chk("R11 rsp_valid", rsp_valid, 0);
    chk("R11 rsp_hit", rsp_hit, 0);
    chk("R11 hit_count", hit_count, 0);
    chk("R11 miss_count", miss_count, 0);
    look("R11 empty", 5, 32'h1234_5678, 12, 0, 0, 0, 0);
  endtask

  task automatic t_basic;
    fill(5, 32'h1234_5678, 12, 32'hABCD_E000, 1);
    look("R1 hit", 5, 32'h1234_5ABC, 12, 0, 1, 0, 32'hABCD_EABC);
    look("R2 other asid", 6, 32'h1234_5ABC, 12, 0, 0, 0, 0);
    look("R1 other page", 5, 32'h1234_6000, 12, 0, 0, 0, 0);
    @(negedge clk);
    chk("R5 idle", rsp_valid, 0);
    fill(10, 32'h00AB_1234, 16, 32'h0077_0000, 1);
    look("R1 gran16", 10, 32'h00AB_FFFF, 16, 0, 1, 0, 32'h0077_FFFF);
  endtask

  task automatic t_perm;
    fill(7, 32'h0000_4000, 12, 32'h0000_9000, 0);
    look("R4 read", 7, 32'h0000_4010, 12, 0, 1, 0, 32'h0000_9010);
    look("R4 write ro", 7, 32'h0000_4010, 12, 1, 1, 1, 32'h0000_9010);
    look("R4 write rw", 5, 32'h1234_5000, 12, 1, 1, 0, 32'hABCD_E000);
    look("R4 write miss", 8, 32'h0000_4010, 12, 1, 0, 0, 0);
  endtask

  task automatic t_same_edge_lookup;
    lk_valid = 1; lk_asid = 5; lk_addr = 32'h1234_5004; lk_gran = 12; lk_write = 0;
    inv_valid = 1; inv_scope = 2'b10; inv_asid = 5; inv_addr = 32'h1234_5000;
    @(negedge clk);
    lk_valid = 0; inv_valid = 0; nh++;
    chk("R5 old contents", rsp_hit, 1);
    chk("R5 old addr", rsp_addr, 32'hABCD_E004);
    look("R7 pair gone", 5, 32'h1234_5004, 12, 0, 0, 0, 0);
  endtask

  task automatic t_scopes;
    inv(2'b00, 0, 0);
    fill(1, 32'h1000, 12, 32'hA000, 1);
    fill(1, 32'h2000, 12, 32'hB000, 1);
    fill(2, 32'h1000, 12, 32'hC000, 1);
    inv(2'b01, 1, 0);
    look("R7 asid A", 1, 32'h1000, 12, 0, 0, 0, 0);
    look("R7 asid B", 1, 32'h2000, 12, 0, 0, 0, 0);
    look("R7 asid keep", 2, 32'h1000, 12, 0, 1, 0, 32'hC000);
    fill(1, 32'h1000, 12, 32'hA000, 1);
    fill(1, 32'h2000, 12, 32'hB000, 1);
    inv(2'b10, 1, 32'h2000);
    look("R7 pair B", 1, 32'h2000, 12, 0, 0, 0, 0);
    look("R7 pair keep A", 1, 32'h1008, 12, 0, 1, 0, 32'hA008);
    inv(2'b11, 2, 32'h1000);
    look("R7 scope3 noop", 2, 32'h1000, 12, 0, 1, 0, 32'hC000);
    inv(2'b00, 0, 0);
    look("R7 all A", 1, 32'h1000, 12, 0, 0, 0, 0);
    look("R7 all C", 2, 32'h1000, 12, 0, 0, 0, 0);
  endtask

  task automatic t_fill_inv;
    fill_valid = 1; fill_asid = 3; fill_addr = 32'h5000; fill_gran = 12;
    fill_page = 32'hD000; fill_wr_ok = 1;
    inv_valid = 1; inv_scope = 2'b00;
    @(negedge clk);
    fill_valid = 0; inv_valid = 0;
    look("R8 fill after inv all", 3, 32'h5000, 12, 0, 1, 0, 32'hD000);
    fill_valid = 1; fill_asid = 3; fill_addr = 32'h6000; fill_page = 32'hE000;
    inv_valid = 1; inv_scope = 2'b01; inv_asid = 3;
    @(negedge clk);
    fill_valid = 0; inv_valid = 0;
    look("R8 old asid gone", 3, 32'h5000, 12, 0, 0, 0, 0);
    look("R8 fill after inv asid", 3, 32'h6000, 12, 0, 1, 0, 32'hE000);
  endtask

  task automatic t_overwrite;
    fill(4, 32'h7000, 12, 32'h0010_0000, 0);
    fill(4, 32'h7ABC, 12, 32'h0020_0000, 1);
    look("R9 overwritten", 4, 32'h7004, 12, 1, 1, 0, 32'h0020_0004);
    look("R9 neighbour", 3, 32'h6000, 12, 0, 1, 0, 32'hE000);
  endtask

  task automatic t_overflow;
    inv(2'b00, 0, 0);
    for (int i = 0; i < 16; i++) fill(9, 32'(i) << 12, 12, 32'h8000_0000 + (32'(i) << 12), 1);
    look("R6 full first", 9, 32'h0000_0010, 12, 0, 1, 0, 32'h8000_0010);
    look("R6 full last", 9, 32'h0000_F010, 12, 0, 1, 0, 32'h8000_F010);
    fill(9, 32'h3000, 12, 32'h9000_0000, 1);
    look("R9 full no flush", 9, 32'h0000_F000, 12, 0, 1, 0, 32'h8000_F000);
    look("R9 full rewrite", 9, 32'h3004, 12, 0, 1, 0, 32'h9000_0004);
    fill(9, 32'h0010_0000, 12, 32'hA000_0000, 1);
    look("R6 flushed first", 9, 32'h0, 12, 0, 0, 0, 0);
    look("R6 flushed last", 9, 32'hF000, 12, 0, 0, 0, 0);
    look("R6 new entry", 9, 32'h0010_0020, 12, 0, 1, 0, 32'hA000_0020);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 16; i++) look("R10 sat hit", 9, 32'h0010_0000, 12, 0, 1, 0, 32'hA000_0000);
    for (int i = 0; i < 16; i++) look("R10 sat miss", 9, 32'h0020_0000, 12, 0, 0, 0, 0);
    chk("R10 hit saturated", hit_count, 15);
    chk("R10 miss saturated", miss_count, 15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_perm;
    t_same_edge_lookup;
    t_scopes;
    t_fill_inv;
    t_overwrite;
    t_overflow;
    t_saturate;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule